// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block owns a connection memory of 512 words of 16 bits and can rewrite all of it in a single hardware sweep. The host programs a 5-bit pattern. Each word gets that pattern in its five most significant bits and zeros in the eleven bits below. The host gets back a ready, uniform memory without issuing hundreds of individual writes. Outside a sweep, the host reaches the memory through a plain write port and a registered read port.

Two host registers drive the sweep. A control register holds a master enable. A mode register holds the pattern and a begin bit. A sweep is launched by the write to the mode register that raises the begin bit, provided the master enable is already set. That same write carries the pattern. The sweep writes one word per clock in ascending address order and then waits out a fixed window of two frame periods. At the end of the window the block clears the begin bit, which is how the host learns the fill is finished.

The host can cancel a running sweep by writing the begin bit to zero or the master enable to zero. The sweep stops on that cycle, and words already written keep their new value. While a sweep runs, host writes to the memory are dropped.

Top module: `cm_block_init`

## Requirements
- R1: After reset, `ctl_reg` and `mode_reg` both read zero.
- R2: A fill starts only on a register write with `reg_sel`=1 (mode register) that takes mode bit 4 (begin) from 0 to 1 while control bit 0 (master) is already 1. A begin bit raised while master is 0 is stored but starts nothing. Setting master afterwards, with begin already 1, also starts nothing.
- R3: Every word written by a fill holds mode bits 9:5 of the start write in word bits 15:11, and zero in bits 10:0.
- R4: A fill writes addresses 0 to DEPTH-1 in ascending order, one per clock. The first write lands on the edge after the one that captures the start write.
- R5: The begin bit (mode bit 4) reads 1 for exactly FRAME_COUNT*FRAME_CYCLES clocks after the edge that captures the start write, and then clears itself. The other mode bits keep their written values.
- R6: A mode-register write with begin=0 during a fill aborts it at once. The word that would have been written in that cycle is not written. Addresses already written keep the pattern, and later addresses keep their previous contents.
- R7: A control-register write with master (bit 0) = 0 during a fill aborts it in the same way as R6. The begin bit keeps its value of 1.
- R8: A host memory write (`mem_we`) is dropped in every cycle of a fill, including its final cycle. Outside a fill, such a write is stored.
- R9: The fill uses the pattern captured at its start. Mode-register writes during the fill that keep begin=1 change `mode_reg` but not the words being filled.
- R10: `mem_rdata` returns the word at `mem_raddr`, registered one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 mode |
| reg_wdata | input | REG_W | Register write data |
| ctl_reg | output | REG_W | Control register value (bit 0 master) |
| mode_reg | output | REG_W | Mode register value (bits 9:5 pattern, bit 4 begin) |
| mem_we | input | 1 | Host memory write strobe |
| mem_waddr | input | ADDR_W | Host memory write address |
| mem_wdata | input | WORD_W | Host memory write data |
| mem_raddr | input | ADDR_W | Host memory read address |
| mem_rdata | output | WORD_W | Registered read data |

## Verification
Two pairs of events are forced into the same clock edge. The first pair is the last cycle of the fill window and a host memory write. The bench counts clocks from the start write so that the host write lands on the very edge where the begin bit clears. A readback must then show the fill word, and the next address, written one edge later, must hold the host's data. The second pair is an abort and a sweep write. The abort lands on a chosen sweep step, and the readback must show the pattern exactly up to the address before that step, with previous contents from there on.

// File: rtl/cmbi_pkg.sv
package cmbi_pkg;
    localparam int PAT_W          = 5;
    localparam int MODE_BEGIN_BIT = 4;
    localparam int MODE_PAT_LSB   = 5;
    localparam int CTL_MASTER_BIT = 0;

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_FILL = 2'd1,
        SW_HOLD = 2'd2
    } sweep_state_e;
endpackage

// File: rtl/cmbi_regs.sv
module cmbi_regs
    import cmbi_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             fill_busy,
    input  logic             fill_done,
    output logic             start_req,
    output logic             abort_req,
    output logic [PAT_W-1:0] start_pat,
    output logic             master_o,
    output logic [REG_W-1:0] ctl_reg,
    output logic [REG_W-1:0] mode_reg
);
    typedef struct packed {
        logic             master;
        logic             beg;
        logic [PAT_W-1:0] pat;
    } regs_t;

    regs_t q, d;
    logic  wr_ctl, wr_mode, new_beg, new_master;
    logic  unused_wdata;

    assign unused_wdata = ^{reg_wdata[REG_W-1:MODE_PAT_LSB+PAT_W], reg_wdata[MODE_BEGIN_BIT-1:1]};

    always_comb begin
        d          = q;
        wr_ctl     = reg_wr && !reg_sel;
        wr_mode    = reg_wr && reg_sel;
        new_beg    = reg_wdata[MODE_BEGIN_BIT];
        new_master = reg_wdata[CTL_MASTER_BIT];
        start_pat  = reg_wdata[MODE_PAT_LSB +: PAT_W];
        start_req  = wr_mode && new_beg && !q.beg && q.master && !fill_busy;
        abort_req  = fill_busy && ((wr_mode && !new_beg) || (wr_ctl && !new_master));
        if (wr_ctl) begin
            d.master = new_master;
        end
        if (wr_mode) begin
            d.beg = new_beg;
            d.pat = start_pat;
        end
        if (fill_done) begin
            d.beg = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign master_o = q.master;
    assign ctl_reg  = REG_W'({q.master});
    assign mode_reg = REG_W'({q.pat, q.beg, {MODE_BEGIN_BIT{1'b0}}});

    AST_DONE_CLEARS_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !q.beg); // R5

    AST_ABORT_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> !start_req); // R6
endmodule

// File: rtl/cmbi_sweep.sv
module cmbi_sweep
    import cmbi_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int WORD_W = 16,
    parameter int WINDOW = 4096,
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              abort_req,
    input  logic [PAT_W-1:0]  start_pat,
    output logic              fill_busy,
    output logic              fill_done,
    output logic              fill_we,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [WORD_W-1:0] fill_word
);
    localparam logic [ADDR_W:0]  LAST_ADDR = (ADDR_W+1)'(DEPTH - 1);
    localparam logic [ADDR_W:0]  END_ADDR  = (ADDR_W+1)'(DEPTH);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(WINDOW - 1);

    typedef struct packed {
        sweep_state_e     st;
        logic [ADDR_W:0]  addr;
        logic [CNT_W-1:0] cnt;
        logic [PAT_W-1:0] pat;
    } sweep_t;

    sweep_t q, d;

    initial begin
        AST_WINDOW_FITS: assert (WINDOW > DEPTH); // R4
    end

    always_comb begin
        d         = q;
        fill_busy = (q.st != SW_IDLE);
        fill_done = fill_busy && (q.cnt == LAST_CNT);
        fill_we   = (q.st == SW_FILL) && !abort_req;
        fill_addr = q.addr[ADDR_W-1:0];
        fill_word = {q.pat, {(WORD_W-PAT_W){1'b0}}};
        unique case (q.st)
            SW_IDLE: begin
                if (start_req) begin
                    d.st   = SW_FILL;
                    d.addr = '0;
                    d.cnt  = '0;
                    d.pat  = start_pat;
                end
            end
            SW_FILL: begin
                d.addr = q.addr + 1'b1;
                d.cnt  = q.cnt + 1'b1;
                if (q.addr == LAST_ADDR) begin
                    d.st = SW_HOLD;
                end
            end
            SW_HOLD: begin
                d.cnt = q.cnt + 1'b1;
            end
            default: begin
                d.st = SW_IDLE;
            end
        endcase
        if (fill_busy && (abort_req || fill_done)) begin
            d.st = SW_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SW_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    AST_FIRST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_busy) |-> fill_addr == '0); // R4

    AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && $past(fill_we)) |-> fill_addr == $past(fill_addr) + 1'b1); // R4

    AST_FULL_COVER: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> q.addr == END_ADDR); // R4

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !fill_busy); // R6
endmodule

// File: rtl/cmbi_mem.sv
module cmbi_mem #(
    parameter int DEPTH  = 512,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_busy,
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [WORD_W-1:0] fill_word,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wr_t;

    logic [WORD_W-1:0] mem_q [DEPTH];
    wr_t               wr_d;
    logic [WORD_W-1:0] rd_d, rd_q;

    always_comb begin
        wr_d = '{en: 1'b0, addr: host_addr, data: host_wdata};
        if (fill_we) begin
            wr_d = '{en: 1'b1, addr: fill_addr, data: fill_word};
        end else if (host_we && !fill_busy) begin
            wr_d.en = 1'b1;
        end
        rd_d = mem_q[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (wr_d.en) begin
            mem_q[wr_d.addr] <= wr_d.data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

    AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_busy && host_we && !(fill_we && fill_addr == host_addr))
        |=> mem_q[$past(host_addr)] == $past(mem_q[host_addr])); // R8

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_d.en |=> rd_data == $past(mem_q[rd_addr])); // R10
endmodule

// File: rtl/cm_block_init.sv
module cm_block_init
    import cmbi_pkg::*;
#(
    parameter int DEPTH        = 512,
    parameter int WORD_W       = 16,
    parameter int REG_W        = 16,
    parameter int FRAME_CYCLES = 2048,
    parameter int FRAME_COUNT  = 2,
    parameter int ADDR_W       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  ctl_reg,
    output logic [REG_W-1:0]  mode_reg,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [WORD_W-1:0] mem_wdata,
    input  logic [ADDR_W-1:0] mem_raddr,
    output logic [WORD_W-1:0] mem_rdata
);
    localparam int WINDOW = FRAME_CYCLES * FRAME_COUNT;
    localparam int CNT_W  = $clog2(WINDOW);

    logic              start_req, abort_req, master;
    logic [PAT_W-1:0]  start_pat;
    logic              fill_busy, fill_done, fill_we;
    logic [ADDR_W-1:0] fill_addr;
    logic [WORD_W-1:0] fill_word;

    cmbi_regs #(.REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .fill_busy (fill_busy),
        .fill_done (fill_done),
        .start_req (start_req),
        .abort_req (abort_req),
        .start_pat (start_pat),
        .master_o  (master),
        .ctl_reg   (ctl_reg),
        .mode_reg  (mode_reg)
    );

    cmbi_sweep #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W),
        .WINDOW (WINDOW),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .abort_req (abort_req),
        .start_pat (start_pat),
        .fill_busy (fill_busy),
        .fill_done (fill_done),
        .fill_we   (fill_we),
        .fill_addr (fill_addr),
        .fill_word (fill_word)
    );

    cmbi_mem #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_busy  (fill_busy),
        .fill_we    (fill_we),
        .fill_addr  (fill_addr),
        .fill_word  (fill_word),
        .host_we    (mem_we),
        .host_addr  (mem_waddr),
        .host_wdata (mem_wdata),
        .rd_addr    (mem_raddr),
        .rd_data    (mem_rdata)
    );

    AST_START_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_busy) |-> ($past(master) && $past(reg_wr && reg_sel && reg_wdata[MODE_BEGIN_BIT]))); // R2

    AST_BUSY_MEANS_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
        fill_busy |-> mode_reg[MODE_BEGIN_BIT]); // R5
endmodule

// File: tb/cm_block_init_tb.sv
module cm_block_init_tb;
    localparam int DEPTH = 512;
    localparam int FRAME_CYCLES = 300;
    localparam int FRAME_COUNT = 2;
    localparam int WIN = FRAME_CYCLES * FRAME_COUNT;

    // pattern[16:12], kind[11:10] (0 none, 1 abort by begin, 2 abort by master), abort step[9:0]
    localparam logic [16:0] VEC [6] = '{
        {5'b10110, 2'd0, 10'd0},
        {5'b00001, 2'd1, 10'd40},
        {5'b11111, 2'd2, 10'd1},
        {5'b01010, 2'd1, 10'd512},
        {5'b00000, 2'd0, 10'd0},
        {5'b11001, 2'd2, 10'd300}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] ctl_reg, mode_reg;
    logic        mem_we = 1'b0;
    logic [8:0]  mem_waddr = '0;
    logic [15:0] mem_wdata = '0;
    logic [8:0]  mem_raddr = '0;
    logic [15:0] mem_rdata;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    cm_block_init #(
        .DEPTH        (DEPTH),
        .FRAME_CYCLES (FRAME_CYCLES),
        .FRAME_COUNT  (FRAME_COUNT)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .ctl_reg   (ctl_reg),
        .mode_reg  (mode_reg),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [15:0] pre_val(input int a, input int v);
        return 16'((a * 37) ^ (v * 16'h1111) ^ 16'h5A5A) | 16'h0001;
    endfunction

    function automatic logic [15:0] fword(input logic [4:0] p);
        return {p, 11'b0};
    endfunction

    function automatic logic [15:0] mword(input logic [4:0] p, input logic b);
        return {6'b0, p, b, 4'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic reg_write(input logic sel, input logic [15:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic mem_write(input int a, input logic [15:0] data);
        mem_we = 1'b1; mem_waddr = 9'(a); mem_wdata = data;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic mem_read(input int a, output logic [15:0] v);
        mem_raddr = 9'(a);
        @(negedge clk);
        v = mem_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n;
        repeat (3) @(negedge clk);
        check("R1 ctl_reg", 32'(ctl_reg), 32'h0);
        check("R1 mode_reg", 32'(mode_reg), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: fill, abort by begin, abort by master
        for (int i = 0; i < 6; i++) begin
            logic [4:0] pat;
            logic [1:0] kind;
            int k;
            string req;
            pat  = VEC[i][16:12];
            kind = VEC[i][11:10];
            k    = int'(VEC[i][9:0]);
            req  = (kind == 2'd0) ? "R3/R4 fill" : ((kind == 2'd1) ? "R6 abort" : "R7 abort");
            reg_write(1'b0, 16'h0001);
            reg_write(1'b1, 16'h0000);
            for (int a = 0; a < DEPTH; a++) mem_write(a, pre_val(a, i));
            mem_read(DEPTH - 1, v);
            check("R10 idle readback", 32'(v), 32'(pre_val(DEPTH - 1, i)));
            reg_write(1'b1, mword(pat, 1'b1));
            if (kind == 2'd0) begin
                n = 0;
                while (mode_reg[4] && n < WIN + 10) begin
                    n++;
                    @(negedge clk);
                end
                check("R5 begin window", 32'(n), 32'(WIN));
                check("R5 mode kept", 32'(mode_reg), 32'(mword(pat, 1'b0)));
            end else begin
                repeat (k - 1) @(negedge clk);
                if (kind == 2'd1) begin
                    reg_write(1'b1, mword(pat, 1'b0));
                    check("R6 begin after abort", 32'(mode_reg[4]), 32'h0);
                end else begin
                    reg_write(1'b0, 16'h0000);
                    check("R7 begin kept", 32'(mode_reg[4]), 32'h1);
                    check("R7 master cleared", 32'(ctl_reg), 32'h0);
                end
            end
            repeat (3) @(negedge clk);
            for (int a = 0; a < DEPTH; a++) begin
                logic [15:0] e;
                e = (kind == 2'd0 || a < k - 1) ? fword(pat) : pre_val(a, i);
                mem_read(a, v);
                check(req, 32'(v), 32'(e));
            end
        end

        // R2: begin raised with master clear, then master set afterwards
        reg_write(1'b0, 16'h0000);
        reg_write(1'b1, 16'h0000);
        mem_write(0, 16'h1234);
        mem_write(7, 16'h5678);
        reg_write(1'b1, mword(5'b10101, 1'b1));
        repeat (20) @(negedge clk);
        check("R2 begin stored", 32'(mode_reg), 32'(mword(5'b10101, 1'b1)));
        mem_read(0, v);
        check("R2 no fill without master", 32'(v), 32'h1234);
        mem_read(7, v);
        check("R2 no fill without master", 32'(v), 32'h5678);
        reg_write(1'b0, 16'h0001);
        repeat (20) @(negedge clk);
        mem_read(0, v);
        check("R2 no fill without transition", 32'(v), 32'h1234);

        // R9: pattern rewritten mid-fill
        reg_write(1'b1, 16'h0000);
        reg_write(1'b1, mword(5'b01101, 1'b1));
        repeat (4) @(negedge clk);
        reg_write(1'b1, mword(5'b10010, 1'b1));
        n = 0;
        while (mode_reg[4] && n < WIN + 10) begin
            n++;
            @(negedge clk);
        end
        check("R9 mode shows new pattern", 32'(mode_reg), 32'(mword(5'b10010, 1'b0)));
        mem_read(0, v);
        check("R9 latched pattern", 32'(v), 32'(fword(5'b01101)));
        mem_read(300, v);
        check("R9 latched pattern", 32'(v), 32'(fword(5'b01101)));
        mem_read(511, v);
        check("R9 latched pattern", 32'(v), 32'(fword(5'b01101)));

        // R8 mid-fill host write, then abort at step 4
        mem_write(400, 16'hBEEF);
        mem_read(400, v);
        check("R8 idle write stored", 32'(v), 32'hBEEF);
        reg_write(1'b1, mword(5'b00110, 1'b1));
        repeat (2) @(negedge clk);
        mem_write(400, 16'h0F0F);
        reg_write(1'b1, mword(5'b00110, 1'b0));
        repeat (2) @(negedge clk);
        mem_read(400, v);
        check("R8 write during fill dropped", 32'(v), 32'hBEEF);
        mem_read(2, v);
        check("R6 last written before abort", 32'(v), 32'(fword(5'b00110)));
        mem_read(3, v);
        check("R6 abort-cycle word not written", 32'(v), 32'(fword(5'b01101)));

        // R8 host write on the completion edge, next one on the following edge
        mem_write(450, 16'h7777);
        mem_read(450, v);
        check("R8 idle write stored", 32'(v), 32'h7777);
        reg_write(1'b1, mword(5'b11100, 1'b1));
        repeat (WIN - 1) @(negedge clk);
        mem_write(450, 16'h3333);
        mem_write(451, 16'h4444);
        check("R5 begin cleared at completion", 32'(mode_reg[4]), 32'h0);
        mem_read(450, v);
        check("R8 write on last fill cycle dropped", 32'(v), 32'(fword(5'b11100)));
        mem_read(451, v);
        check("R8 write after fill stored", 32'(v), 32'h4444);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule